// File: doc/BRIEF.md
# SDRAM Open-Row Write Command Scheduler

This block sits between a bus master that issues write requests and an SDRAM device. Each request carries a bank, a row, a column, a data word and a flag that marks it as the next beat of a sequential burst. The scheduler turns each request into SDRAM commands and remembers which row is open in every bank. A write to the row already open in its bank goes out at once as a single WRITE. A write to a closed bank first opens the row with ACTIVE. A write to a bank holding a different row first closes that row with PRECHARGE, then opens the new one, then writes. A sequential write that wraps a page is handled like a row change.

The precharge-to-activate and activate-to-write spacings come from two configuration inputs counted in clock cycles. A free-running interval timer asks for an auto-refresh. When it fires, the scheduler lets the sequence in progress finish. It then precharges all banks, issues AUTO-REFRESH and forgets every open row. For a 100 MHz clock, the interval input would be 1562 for a 15.625 µs period or 781 for a 7.81 µs period. Requests use a valid/ready handshake. Ready stays high between back-to-back row hits, so a burst inside one row runs at one write per cycle.

Top module: `sdram_wr_sched`

## Requirements
- R1: After reset, req_ready is 1, the command outputs show NOP, sd_dq_en is 0, and every bank is closed.
- R2: Commands appear on {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} as follows: ACTIVE = 0011, WRITE = 0100, PRECHARGE = 0010, AUTO-REFRESH = 0001, NOP = 0111.
- R3: An accepted write whose bank holds the requested row gives one WRITE in the cycle after acceptance. That WRITE carries the bank on sd_ba, the column zero-extended on sd_addr, the data on sd_dq, and sd_dq_en = 1. sd_dq_en is 0 whenever no WRITE is shown.
- R4: An accepted write to a closed bank gives ACTIVE (row on sd_addr) in the cycle after acceptance, followed by its WRITE.
- R5: An accepted write to a bank holding another row gives PRECHARGE for that bank with sd_pre_all = 0 in the cycle after acceptance, then ACTIVE for the new row, then the WRITE.
- R6: A request with the sequential flag set and column 0 counts as a page crossing. It gets the PRECHARGE, ACTIVE, WRITE sequence even when its row is open. The same request with the flag clear is a plain hit.
- R7: ACTIVE follows its PRECHARGE by exactly max(cfg_trp,1) cycles. WRITE follows its ACTIVE by exactly max(cfg_trcd,1) cycles.
- R8: req_ready is 0 from the cycle after a non-hit request is accepted until its WRITE is shown. Row hits keep req_ready at 1, so consecutive hits produce WRITEs on consecutive cycles.
- R9: With no traffic, a refresh starts every max(cfg_refi,1) cycles. It is a PRECHARGE with sd_pre_all = 1, followed max(cfg_trp,1) cycles later by AUTO-REFRESH.
- R10: After a refresh every bank is closed, so the next write to a row that was open before gets ACTIVE with no PRECHARGE.
- R11: req_ready is 0 while a refresh is pending and while its all-bank precharge waits.
- R12: Each bank keeps its own open row. Opening a row in one bank does not change the hit or miss outcome in any other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_trp | input | TW | Precharge-to-activate spacing in cycles (0 acts as 1) |
| cfg_trcd | input | TW | Activate-to-write spacing in cycles (0 acts as 1) |
| cfg_refi | input | REF_W | Refresh interval in cycles (0 acts as 1) |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request accepted on a clock edge where both are high |
| req_bank | input | BA_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_seq | input | 1 | Sequential burst beat |
| req_data | input | DATA_W | Write data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Row for ACTIVE, column for WRITE |
| sd_pre_all | output | 1 | Precharge applies to all banks |
| sd_dq | output | DATA_W | Write data |
| sd_dq_en | output | 1 | Data bus driven |

## Verification
The bench sweeps every combination of precharge and activate spacings from 0 to 3 cycles. For each one it drives writes to closed banks, row hits, row misses and page-crossing sequential beats in all four banks. It predicts every command, field and cycle from its own open-row model. A design that counted its wait from the wrong register would put ACTIVE or WRITE one cycle early or late. A design that ignored the zero-column sequential case would emit a bare WRITE to a page it never reopened. A design that let bank tables alias would miss a needed PRECHARGE, and one that kept rows open across a refresh would write to a closed bank. The refresh run measures the spacing between two all-bank precharges and checks that ready is low during them. A back-to-back run shows that row hits do not stall.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001
    } sd_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RP     = 2'd1,
        ST_RCD    = 2'd2,
        ST_REF_RP = 2'd3
    } sched_st_e;

endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int REF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REF_W-1:0] cfg_interval,
    output logic             tick
);

    logic [REF_W-1:0] cnt_d, cnt_q;
    logic [REF_W-1:0] limit;

    always_comb begin
        limit = (cfg_interval == '0) ? '0 : cfg_interval - REF_W'(1);
        tick  = (cnt_q >= limit);
        cnt_d = tick ? '0 : cnt_q + REF_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/sdram_row_table.sv
module sdram_row_table #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int BA_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [BA_W-1:0]  set_bank,
    input  logic [ROW_W-1:0] set_row,
    input  logic             clr_en,
    input  logic [BA_W-1:0]  clr_bank,
    input  logic             clr_all,
    input  logic [BA_W-1:0]  look_bank,
    output logic             look_open,
    output logic [ROW_W-1:0] look_row
);

    logic [NUM_BANKS-1:0] open_d, open_q;
    logic [ROW_W-1:0]     row_d [NUM_BANKS];
    logic [ROW_W-1:0]     row_q [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        always_comb begin
            open_d[g] = open_q[g];
            row_d[g]  = row_q[g];
            if (clr_all || (clr_en && clr_bank == BA_W'(g))) begin
                open_d[g] = 1'b0;
            end
            if (set_en && set_bank == BA_W'(g)) begin
                open_d[g] = 1'b1;
                row_d[g]  = set_row;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                open_q[g] <= 1'b0;
                row_q[g]  <= '0;
            end else begin
                open_q[g] <= open_d[g];
                row_q[g]  <= row_d[g];
            end
        end
    end

    always_comb begin
        look_open = 1'b0;
        look_row  = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (look_bank == BA_W'(i)) begin
                look_open = open_q[i];
                look_row  = row_q[i];
            end
        end
    end

endmodule

// File: rtl/sdram_wr_sched.sv
module sdram_wr_sched #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int DATA_W    = 16,
    parameter int TW        = 4,
    parameter int REF_W     = 16,
    localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW-1:0]     cfg_trp,
    input  logic [TW-1:0]     cfg_trcd,
    input  logic [REF_W-1:0]  cfg_refi,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BA_W-1:0]   req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_seq,
    input  logic [DATA_W-1:0] req_data,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              sd_pre_all,
    output logic [DATA_W-1:0] sd_dq,
    output logic              sd_dq_en
);
    import sdram_wr_pkg::*;

    typedef struct packed {
        sched_st_e         state;
        sd_cmd_e           cmd;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
        logic              pre_all;
        logic [DATA_W-1:0] dq;
        logic              dq_en;
        logic [TW-1:0]     cnt;
        logic [BA_W-1:0]   t_bank;
        logic [ROW_W-1:0]  t_row;
        logic [COL_W-1:0]  t_col;
        logic [DATA_W-1:0] t_data;
        logic              ref_pend;
    } regs_t;

    localparam regs_t REGS_RST = '{
        state: ST_IDLE, cmd: CMD_NOP, ba: '0, addr: '0, pre_all: 1'b0,
        dq: '0, dq_en: 1'b0, cnt: '0, t_bank: '0, t_row: '0, t_col: '0,
        t_data: '0, ref_pend: 1'b0
    };

    regs_t r_d, r_q;

    logic             ref_tick;
    logic             tbl_set, tbl_clr, tbl_clr_all;
    logic [BA_W-1:0]  tbl_set_bank, tbl_clr_bank;
    logic [ROW_W-1:0] tbl_set_row;
    logic             look_open;
    logic [ROW_W-1:0] look_row;
    logic [TW-1:0]    rp_load, rcd_load;
    logic             row_hit, page_cross;

    sdram_refresh_timer #(.REF_W(REF_W)) i_ref_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_interval (cfg_refi),
        .tick         (ref_tick)
    );

    sdram_row_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .BA_W(BA_W)) i_row_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (tbl_set),
        .set_bank  (tbl_set_bank),
        .set_row   (tbl_set_row),
        .clr_en    (tbl_clr),
        .clr_bank  (tbl_clr_bank),
        .clr_all   (tbl_clr_all),
        .look_bank (req_bank),
        .look_open (look_open),
        .look_row  (look_row)
    );

    assign req_ready = (r_q.state == ST_IDLE) && !r_q.ref_pend;

    always_comb begin
        rp_load    = (cfg_trp  == '0) ? '0 : cfg_trp  - TW'(1);
        rcd_load   = (cfg_trcd == '0) ? '0 : cfg_trcd - TW'(1);
        page_cross = req_seq && (req_col == '0);
        row_hit    = look_open && (look_row == req_row) && !page_cross;

        r_d          = r_q;
        r_d.cmd      = CMD_NOP;
        r_d.pre_all  = 1'b0;
        r_d.dq_en    = 1'b0;
        tbl_set      = 1'b0;
        tbl_set_bank = r_q.t_bank;
        tbl_set_row  = r_q.t_row;
        tbl_clr      = 1'b0;
        tbl_clr_bank = req_bank;
        tbl_clr_all  = 1'b0;

        if (ref_tick) r_d.ref_pend = 1'b1;

        unique case (r_q.state)
            ST_IDLE: begin
                if (r_q.ref_pend) begin
                    r_d.cmd      = CMD_PRE;
                    r_d.pre_all  = 1'b1;
                    r_d.cnt      = rp_load;
                    r_d.state    = ST_REF_RP;
                    r_d.ref_pend = ref_tick;
                    tbl_clr_all  = 1'b1;
                end else if (req_valid) begin
                    r_d.t_bank = req_bank;
                    r_d.t_row  = req_row;
                    r_d.t_col  = req_col;
                    r_d.t_data = req_data;
                    r_d.ba     = req_bank;
                    if (row_hit) begin
                        r_d.cmd   = CMD_WR;
                        r_d.addr  = ADDR_W'(req_col);
                        r_d.dq    = req_data;
                        r_d.dq_en = 1'b1;
                    end else if (look_open) begin
                        r_d.cmd   = CMD_PRE;
                        r_d.cnt   = rp_load;
                        r_d.state = ST_RP;
                        tbl_clr   = 1'b1;
                    end else begin
                        r_d.cmd      = CMD_ACT;
                        r_d.addr     = ADDR_W'(req_row);
                        r_d.cnt      = rcd_load;
                        r_d.state    = ST_RCD;
                        tbl_set      = 1'b1;
                        tbl_set_bank = req_bank;
                        tbl_set_row  = req_row;
                    end
                end
            end
            ST_RP: begin
                if (r_q.cnt == '0) begin
                    r_d.cmd   = CMD_ACT;
                    r_d.ba    = r_q.t_bank;
                    r_d.addr  = ADDR_W'(r_q.t_row);
                    r_d.cnt   = rcd_load;
                    r_d.state = ST_RCD;
                    tbl_set   = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - TW'(1);
                end
            end
            ST_RCD: begin
                if (r_q.cnt == '0) begin
                    r_d.cmd   = CMD_WR;
                    r_d.ba    = r_q.t_bank;
                    r_d.addr  = ADDR_W'(r_q.t_col);
                    r_d.dq    = r_q.t_data;
                    r_d.dq_en = 1'b1;
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - TW'(1);
                end
            end
            ST_REF_RP: begin
                if (r_q.cnt == '0) begin
                    r_d.cmd   = CMD_REF;
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - TW'(1);
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = r_q.cmd;
    assign sd_ba      = r_q.ba;
    assign sd_addr    = r_q.addr;
    assign sd_pre_all = r_q.pre_all;
    assign sd_dq      = r_q.dq;
    assign sd_dq_en   = r_q.dq_en;

endmodule

// File: rtl/sdram_wr_sched_chk.sv
module sdram_wr_sched_chk #(
    parameter int TW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    cmd,
    input logic          pre_all,
    input logic          dq_en,
    input logic          req_valid,
    input logic          req_ready,
    input logic [TW-1:0] cfg_trp,
    input logic [TW-1:0] cfg_trcd
);
    import sdram_wr_pkg::*;

    logic [3:0] last_q;
    logic       last_all_q;
    logic [7:0] since_q;
    logic [7:0] rp_min, rcd_min;

    assign rp_min  = (cfg_trp  == '0) ? 8'd1 : 8'(cfg_trp);
    assign rcd_min = (cfg_trcd == '0) ? 8'd1 : 8'(cfg_trcd);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q     <= CMD_NOP;
            last_all_q <= 1'b0;
            since_q    <= 8'd0;
        end else if (cmd != CMD_NOP) begin
            last_q     <= cmd;
            last_all_q <= pre_all;
            since_q    <= 8'd1;
        end else if (since_q != 8'hFF) begin
            since_q <= since_q + 8'd1;
        end
    end

    p_cmd_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd inside {CMD_NOP, CMD_ACT, CMD_WR, CMD_PRE, CMD_REF});

    p_dq_with_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WR) == dq_en);

    p_accept_issues_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (cmd inside {CMD_ACT, CMD_WR, CMD_PRE}));

    p_act_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT && last_q == CMD_PRE) |-> (since_q == rp_min));

    p_wr_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WR && last_q == CMD_ACT) |-> (since_q == rcd_min));

    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE || cmd == CMD_ACT) |-> !req_ready);

    p_ref_after_preall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF) |-> (last_q == CMD_PRE && last_all_q));

endmodule

bind sdram_wr_sched sdram_wr_sched_chk #(.TW(TW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
    .pre_all   (sd_pre_all),
    .dq_en     (sd_dq_en),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cfg_trp   (cfg_trp),
    .cfg_trcd  (cfg_trcd)
);

// File: tb/test_sdram_wr_sched.sv
`timescale 1ns/1ps
module test_sdram_wr_sched;
    localparam int NB = 4, RW = 4, CW = 3, DW = 8, TW = 4, REFW = 16;
    localparam int BAW = 2, AW = 4;
    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_WR = 4'b0100,
                           C_PRE = 4'b0010, C_REF = 4'b0001;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [TW-1:0] cfg_trp = '0, cfg_trcd = '0;
    logic [REFW-1:0] cfg_refi = 16'hFFFF;
    logic req_valid = 1'b0, req_ready, req_seq = 1'b0;
    logic [BAW-1:0] req_bank = '0;
    logic [RW-1:0] req_row = '0;
    logic [CW-1:0] req_col = '0;
    logic [DW-1:0] req_data = '0;
    logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_pre_all, sd_dq_en;
    logic [BAW-1:0] sd_ba;
    logic [AW-1:0] sd_addr;
    logic [DW-1:0] sd_dq;

    sdram_wr_sched #(.NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .DATA_W(DW),
                     .TW(TW), .REF_W(REFW)) i_sdram_wr_sched (
        .clk(clk), .rst_n(rst_n), .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd),
        .cfg_refi(cfg_refi), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_seq(req_seq), .req_data(req_data), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_pre_all(sd_pre_all),
        .sd_dq(sd_dq), .sd_dq_en(sd_dq_en));

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // command log, filled at the falling edge
    logic [3:0]     lg_cmd [512];
    logic [BAW-1:0] lg_ba  [512];
    logic [AW-1:0]  lg_addr[512];
    logic           lg_all [512];
    logic [DW-1:0]  lg_dq  [512];
    logic           lg_dqen[512];
    logic           lg_rdy [512];
    int             lg_cyc [512];
    int             lg_n = 0;

    always @(negedge clk) begin
        if (rst_n && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != C_NOP && lg_n < 512) begin
            lg_cmd[lg_n]  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            lg_ba[lg_n]   = sd_ba;
            lg_addr[lg_n] = sd_addr;
            lg_all[lg_n]  = sd_pre_all;
            lg_dq[lg_n]   = sd_dq;
            lg_dqen[lg_n] = sd_dq_en;
            lg_rdy[lg_n]  = req_ready;
            lg_cyc[lg_n]  = cyc;
            lg_n = lg_n + 1;
        end
    end

    bit mv [NB];
    int mr [NB];

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic do_reset();
        req_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        lg_n = 0;
        for (int b = 0; b < NB; b++) mv[b] = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic do_wr(input int b, input int row, input int col, input bit seq, input int data);
        int s, acc, kind, rp, rcd, n, i;
        string rq;
        rp  = (cfg_trp  == 0) ? 1 : int'(cfg_trp);
        rcd = (cfg_trcd == 0) ? 1 : int'(cfg_trcd);
        if (mv[b] && mr[b] == row && !(seq && col == 0)) begin kind = 0; rq = "R3"; end
        else if (mv[b]) begin kind = 2; rq = (mr[b] == row) ? "R6" : "R5"; end
        else begin kind = 1; rq = "R4"; end
        mv[b] = 1'b1; mr[b] = row;
        s = lg_n;
        @(negedge clk);
        req_valid = 1'b1; req_bank = BAW'(b); req_row = RW'(row);
        req_col = CW'(col); req_seq = seq; req_data = DW'(data);
        while (req_ready !== 1'b1) @(negedge clk);
        @(negedge clk);
        acc = cyc;
        req_valid = 1'b0;
        chk("R8", "ready after accept", req_ready, (kind == 0) ? 1 : 0);
        repeat (12) @(negedge clk);
        n = (kind == 0) ? 1 : (kind == 1) ? 2 : 3;
        chk(rq, "command count", lg_n - s, n);
        if (lg_n - s == n) begin
            i = s;
            if (kind == 2) begin
                chk(rq, "PRE code (R2)", lg_cmd[i], C_PRE);
                chk(rq, "PRE cycle", lg_cyc[i], acc);
                chk(rq, "PRE bank", lg_ba[i], b);
                chk(rq, "PRE single bank", lg_all[i], 0);
                i++;
            end
            if (kind != 0) begin
                chk(rq, "ACT code (R2)", lg_cmd[i], C_ACT);
                chk("R7", "ACT cycle", lg_cyc[i], acc + ((kind == 2) ? rp : 0));
                chk(rq, "ACT bank", lg_ba[i], b);
                chk(rq, "ACT row", lg_addr[i], row);
                i++;
            end
            chk(rq, "WRITE code (R2)", lg_cmd[i], C_WR);
            chk("R7", "WRITE cycle", lg_cyc[i],
                acc + ((kind == 2) ? rp : 0) + ((kind != 0) ? rcd : 0));
            chk("R3", "WRITE bank", lg_ba[i], b);
            chk("R3", "WRITE column", lg_addr[i], col);
            chk("R3", "WRITE data", lg_dq[i], DW'(data));
            chk("R3", "WRITE dq_en", lg_dqen[i], 1);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int s, a0, p1, p2, nref;
        do_reset();
        @(negedge clk);
        chk("R1", "ready after reset", req_ready, 1);
        chk("R1", "NOP after reset (R2)", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
        chk("R1", "dq_en after reset", sd_dq_en, 0);

        // sweep over spacing configurations
        for (int rp = 0; rp < 4; rp++) begin
            for (int rc = 0; rc < 4; rc++) begin
                cfg_trp = TW'(rp); cfg_trcd = TW'(rc); cfg_refi = 16'hFFFF;
                do_reset();
                for (int b = 0; b < NB; b++) begin
                    do_wr(b, b, 1, 1'b0, 16 * b + 1);      // closed bank: R4
                    do_wr(b, b, 2, 1'b1, 16 * b + 2);      // hit: R3
                    do_wr(b, b, 0, 1'b0, 16 * b + 3);      // col 0 non-seq hit: R6
                    do_wr(b, b, 0, 1'b1, 16 * b + 4);      // page crossing: R6
                    do_wr(b, b + 5, 3, 1'b0, 16 * b + 5);  // row change: R5
                end
                for (int b = 0; b < NB; b++)
                    do_wr(b, b + 5, 4, 1'b0, 16 * b + 6);  // R12: every bank still hits
            end
        end

        // back-to-back hits: R8
        cfg_trp = 4'd1; cfg_trcd = 4'd1;
        do_reset();
        do_wr(2, 7, 0, 1'b0, 8'h70);
        s = lg_n;
        a0 = 0;
        @(negedge clk);
        req_valid = 1'b1; req_bank = 2'd2; req_row = 4'd7; req_seq = 1'b1;
        req_col = 3'd1; req_data = 8'h81;
        for (int i = 2; i <= 5; i++) begin
            @(negedge clk);
            if (i == 2) a0 = cyc;
            chk("R8", "ready during hit burst", req_ready, 1);
            if (i <= 4) begin req_col = CW'(i); req_data = DW'(8'h80 + i); end
            else req_valid = 1'b0;
        end
        repeat (4) @(negedge clk);
        chk("R8", "burst write count", lg_n - s, 4);
        if (lg_n - s == 4) begin
            for (int k = 0; k < 4; k++) begin
                chk("R8", "burst WRITE code", lg_cmd[s + k], C_WR);
                chk("R8", "burst WRITE cycle", lg_cyc[s + k], a0 + k);
                chk("R3", "burst WRITE column", lg_addr[s + k], k + 1);
            end
        end

        // refresh: R9, R10, R11
        cfg_trp = 4'd2; cfg_trcd = 4'd1; cfg_refi = 16'd40;
        do_reset();
        do_wr(1, 3, 2, 1'b0, 8'h33);
        s = lg_n;
        nref = 0;
        for (int w = 0; w < 200 && nref < 2; w++) begin
            @(negedge clk);
            nref = 0;
            for (int k = s; k < lg_n; k++) if (lg_cmd[k] == C_REF) nref++;
        end
        cfg_refi = 16'hFFFF;
        p1 = -1; p2 = -1;
        for (int k = s; k < lg_n; k++) begin
            if (lg_cmd[k] == C_PRE && lg_all[k]) begin
                if (p1 < 0) p1 = k; else if (p2 < 0) p2 = k;
            end
        end
        chk("R9", "refresh sequences seen", nref, 2);
        chk("R9", "two all-bank precharges", (p1 >= 0 && p2 >= 0) ? 1 : 0, 1);
        if (p1 >= 0 && p2 >= 0) begin
            chk("R9", "refresh period", lg_cyc[p2] - lg_cyc[p1], 40);
            chk("R9", "REF follows precharge-all", lg_cmd[p1 + 1], C_REF);
            chk("R9", "REF spacing", lg_cyc[p1 + 1] - lg_cyc[p1], 2);
            chk("R11", "ready at precharge-all", lg_rdy[p1], 0);
            chk("R11", "ready at second precharge-all", lg_rdy[p2], 0);
        end
        for (int b = 0; b < NB; b++) mv[b] = 1'b0;
        do_wr(1, 3, 5, 1'b0, 8'h35);   // R10: needs ACT, no PRE

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule